// File: doc/BRIEF.md
# Peripheral Address Decode and Status Gating

This block connects an 8-bit processor bus to a small set of peripheral registers. It watches the 16-bit address, the valid-address flag, the read/write line and the phase-2 clock level. From these it produces single-purpose strobes. Read strobes gate the drift-angle source, the air-data source and the receive register onto the bus. Write strobes move bus data into the two halves of the transmit register. The receive-register strobe is granted only while a self-test sequence is servicing a transmit-register interrupt.

Two fixed addresses return status bytes built from plain level inputs. The first holds the video, link and encoder conditions, plus two self-test request flags that are captured in sticky registers. The second holds the antenna side. A write to the first status address clears the sticky request flags. The block also drives the data-transceiver enable and direction, and the address-driver enable. When bus-available is high, the processor is cut off from both buses so that other logic can use them.

Top module: `periph_bus_gate`

## Requirements
- R1: With valid-address high, phase-2 high, bus-available low and read (rw=1), address 0x200A asserts `drift_rd_stb` and address 0x2004 asserts `adas_rd_stb`.
- R2: With the same qualifiers but write (rw=0), address 0x0006 asserts `txlo_wr_stb` and address 0x0007 asserts `txhi_wr_stb`.
- R3: `rx_rd_stb` asserts for a qualified read of 0x2008 only while both `bite_active` and `xmit_irq` are high.
- R4: No strobe asserts when valid-address is low, phase-2 is low, bus-available is high, or the direction does not match the address's role. At most one strobe is high at a time.
- R5: A qualified read of 0x2000 sets `rd_oe` and returns the following `rd_data`: bit7 = transition detect, bit6 = field select, bit5 = link fault, bit4 = latched downlink test request, bit3 = latched airborne test request, bit2 = encoder standby, bit1 = halt, bit0 = 0.
- R6: A qualified read of 0x2002 sets `rd_oe` and returns `ant_right` in bit1, with every other bit 0.
- R7: Each test-request flag is set on the clock edge where its input is high. It stays set after the input falls.
- R8: A qualified write to 0x2000 clears both request flags at the next clock edge. A request input that is high at that same edge keeps its flag set.
- R9: Outside a qualified status read, `rd_oe` is 0 and `rd_data` is 0x00.
- R10: `xcvr_en_n` is low only when bus-available is low and valid-address and phase-2 are both high. `xcvr_to_cpu` equals `rw` while the transceiver is enabled and is 0 otherwise.
- R11: `addr_drv_en_n` follows bus-available: it is low (drivers on) only while `ba` is low.
- R12: While reset is asserted, and through the synchronous release, both request flags read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the request flags |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address |
| vma | input | 1 | Valid-address flag |
| rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Phase-2 clock level |
| ba | input | 1 | Bus-available; high hands buses away |
| bite_active | input | 1 | Self-test sequence running |
| xmit_irq | input | 1 | Transmit-register interrupt pending |
| xdet | input | 1 | Transition-detect status |
| fsel | input | 1 | Field-select status |
| halt_st | input | 1 | Video transfer halt status |
| link_fault | input | 1 | Link sync or power fault |
| enc_standby | input | 1 | Encoder in standby |
| air_test_req | input | 1 | Airborne test request |
| down_test_req | input | 1 | Downlink test request |
| ant_right | input | 1 | Antenna side, 1 = right |
| drift_rd_stb | output | 1 | Drift-angle read strobe |
| adas_rd_stb | output | 1 | Air-data read strobe |
| rx_rd_stb | output | 1 | Receive-register read strobe |
| txlo_wr_stb | output | 1 | Transmit-register low write strobe |
| txhi_wr_stb | output | 1 | Transmit-register high write strobe |
| rd_oe | output | 1 | Status byte on bus |
| rd_data | output | 8 | Status byte |
| xcvr_en_n | output | 1 | Data transceiver enable, active low |
| xcvr_to_cpu | output | 1 | Transceiver direction, 1 = toward processor |
| addr_drv_en_n | output | 1 | Address driver enable, active low |

## Verification
Most of the block is combinational, so a decode fault appears at the strobe and data ports in the same cycle as the bus pattern that exposes it. The only stored state is the pair of request flags. A flag that is stuck, fails to hold, or clears at the wrong time appears only when the status byte at 0x2000 is next read. For that reason the stimulus places frequent status reads around request pulses and clear writes, and it includes the cycle where a clear and a request coincide.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  // select slots decoded from the address
  localparam int SEL_DRIFT = 0;
  localparam int SEL_ADAS  = 1;
  localparam int SEL_RX    = 2;
  localparam int SEL_TXLO  = 3;
  localparam int SEL_TXHI  = 4;
  localparam int SEL_STAT  = 5;
  localparam int SEL_ANT   = 6;
  localparam int NSEL      = 7;
endpackage

// File: rtl/pbg_decode.sv
module pbg_decode
  import pbg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] A_DRIFT = 16'h200A,
  parameter logic [ADDR_W-1:0] A_ADAS  = 16'h2004,
  parameter logic [ADDR_W-1:0] A_RX    = 16'h2008,
  parameter logic [ADDR_W-1:0] A_TXLO  = 16'h0006,
  parameter logic [ADDR_W-1:0] A_TXHI  = 16'h0007,
  parameter logic [ADDR_W-1:0] A_STAT  = 16'h2000,
  parameter logic [ADDR_W-1:0] A_ANT   = 16'h2002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vma,
  input  logic              rw,
  input  logic              phi2,
  input  logic              ba,
  input  logic              bite_active,
  input  logic              xmit_irq,
  output logic              drift_rd_stb,
  output logic              adas_rd_stb,
  output logic              rx_rd_stb,
  output logic              txlo_wr_stb,
  output logic              txhi_wr_stb,
  output logic              stat_rd,
  output logic              ant_rd,
  output logic              stat_wr
);
  localparam logic [ADDR_W-1:0] SEL_ADDR [NSEL] =
    '{A_DRIFT, A_ADAS, A_RX, A_TXLO, A_TXHI, A_STAT, A_ANT};

  logic [NSEL-1:0] hit;
  logic            cyc_ok;
  logic            rd_cyc;
  logic            wr_cyc;

  for (genvar i = 0; i < NSEL; i++) begin : g_cmp
    assign hit[i] = (addr == SEL_ADDR[i]);
  end

  always_comb begin
    cyc_ok       = vma & phi2 & ~ba;
    rd_cyc       = cyc_ok & rw;
    wr_cyc       = cyc_ok & ~rw;
    drift_rd_stb = rd_cyc & hit[SEL_DRIFT];
    adas_rd_stb  = rd_cyc & hit[SEL_ADAS];
    rx_rd_stb    = rd_cyc & hit[SEL_RX] & bite_active & xmit_irq;
    txlo_wr_stb  = wr_cyc & hit[SEL_TXLO];
    txhi_wr_stb  = wr_cyc & hit[SEL_TXHI];
    stat_rd      = rd_cyc & hit[SEL_STAT];
    ant_rd       = rd_cyc & hit[SEL_ANT];
    stat_wr      = wr_cyc & hit[SEL_STAT];
  end

  // R4: strobes are mutually exclusive
  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drift_rd_stb, adas_rd_stb, rx_rd_stb, txlo_wr_stb, txhi_wr_stb}));
  // R3: receive strobe only within a self-test interrupt service
  assert_rx_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_stb |-> (bite_active && xmit_irq && rw));
  // R4: no strobe once the bus is handed away
  assert_ba_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ba |-> !(drift_rd_stb || adas_rd_stb || rx_rd_stb || txlo_wr_stb || txhi_wr_stb));
endmodule

// File: rtl/pbg_status.sv
module pbg_status
  import pbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              ant_rd,
  input  logic              stat_wr,
  input  logic              xdet,
  input  logic              fsel,
  input  logic              halt_st,
  input  logic              link_fault,
  input  logic              enc_standby,
  input  logic              air_test_req,
  input  logic              down_test_req,
  input  logic              ant_right,
  output logic              rd_oe,
  output logic [DATA_W-1:0] rd_data
);
  logic air_q, air_d;
  logic down_q, down_d;
  logic req_en;

  // next state: set wins over clear
  always_comb begin
    req_en = air_test_req | down_test_req | stat_wr;
    air_d  = air_test_req  | (air_q  & ~stat_wr);
    down_d = down_test_req | (down_q & ~stat_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      air_q  <= 1'b0;
      down_q <= 1'b0;
    end else if (req_en) begin
      air_q  <= air_d;
      down_q <= down_d;
    end
  end

  always_comb begin
    rd_oe   = stat_rd | ant_rd;
    rd_data = '0;
    if (stat_rd)
      rd_data = {xdet, fsel, link_fault, down_q, air_q, enc_standby, halt_st, 1'b0};
    else if (ant_rd)
      rd_data = {6'b0, ant_right, 1'b0};
  end

  // R7: a captured request survives until a clear write
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(air_q) && !$past(stat_wr)) |-> air_q);
  // R8: clear write without a new request empties the flag
  assert_req_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_wr) && !$past(down_test_req)) |-> !down_q);
  // R9: bus quiet when no status read
  assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));
endmodule

// File: rtl/pbg_bus_ctl.sv
module pbg_bus_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic vma,
  input  logic phi2,
  input  logic rw,
  input  logic ba,
  output logic xcvr_en_n,
  output logic xcvr_to_cpu,
  output logic addr_drv_en_n
);
  logic xcvr_on;

  always_comb begin
    xcvr_on       = ~ba & vma & phi2;
    xcvr_en_n     = ~xcvr_on;
    xcvr_to_cpu   = xcvr_on & rw;
    addr_drv_en_n = ba;
  end

  // R10/R11: bus handed away means both drivers off
  assert_ba_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ba |-> (xcvr_en_n && addr_drv_en_n && !xcvr_to_cpu));
  // R10: no processor drive without a valid address
  assert_xcvr_vma_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_en_n |-> (vma && phi2));
endmodule

// File: rtl/periph_bus_gate.sv
module periph_bus_gate
  import pbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vma,
  input  logic              rw,
  input  logic              phi2,
  input  logic              ba,
  input  logic              bite_active,
  input  logic              xmit_irq,
  input  logic              xdet,
  input  logic              fsel,
  input  logic              halt_st,
  input  logic              link_fault,
  input  logic              enc_standby,
  input  logic              air_test_req,
  input  logic              down_test_req,
  input  logic              ant_right,
  output logic              drift_rd_stb,
  output logic              adas_rd_stb,
  output logic              rx_rd_stb,
  output logic              txlo_wr_stb,
  output logic              txhi_wr_stb,
  output logic              rd_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              xcvr_en_n,
  output logic              xcvr_to_cpu,
  output logic              addr_drv_en_n
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       stat_rd, ant_rd, stat_wr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pbg_decode u_dec (
    .clk(clk), .rst_n(rst_int_n), .addr(addr), .vma(vma), .rw(rw),
    .phi2(phi2), .ba(ba), .bite_active(bite_active), .xmit_irq(xmit_irq),
    .drift_rd_stb(drift_rd_stb), .adas_rd_stb(adas_rd_stb),
    .rx_rd_stb(rx_rd_stb), .txlo_wr_stb(txlo_wr_stb),
    .txhi_wr_stb(txhi_wr_stb), .stat_rd(stat_rd), .ant_rd(ant_rd),
    .stat_wr(stat_wr)
  );

  pbg_status u_stat (
    .clk(clk), .rst_n(rst_int_n), .stat_rd(stat_rd), .ant_rd(ant_rd),
    .stat_wr(stat_wr), .xdet(xdet), .fsel(fsel), .halt_st(halt_st),
    .link_fault(link_fault), .enc_standby(enc_standby),
    .air_test_req(air_test_req), .down_test_req(down_test_req),
    .ant_right(ant_right), .rd_oe(rd_oe), .rd_data(rd_data)
  );

  pbg_bus_ctl u_bus (
    .clk(clk), .rst_n(rst_int_n), .vma(vma), .phi2(phi2), .rw(rw),
    .ba(ba), .xcvr_en_n(xcvr_en_n), .xcvr_to_cpu(xcvr_to_cpu),
    .addr_drv_en_n(addr_drv_en_n)
  );
endmodule

// File: tb/periph_bus_gate_test.sv
module periph_bus_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic vma = 0, rw = 0, phi2 = 0, ba = 0, bite_active = 0, xmit_irq = 0;
  logic xdet = 0, fsel = 0, halt_st = 0, link_fault = 0, enc_standby = 0;
  logic air_test_req = 0, down_test_req = 0, ant_right = 0;
  logic drift_rd_stb, adas_rd_stb, rx_rd_stb, txlo_wr_stb, txhi_wr_stb;
  logic rd_oe, xcvr_en_n, xcvr_to_cpu, addr_drv_en_n;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;
  logic m_air = 0, m_down = 0;
  bit done = 0;

  always #10 clk = ~clk;

  periph_bus_gate uut (.*);

  function automatic logic [4:0] exp_stb();
    logic ok = vma & phi2 & ~ba;
    return {ok & rw  & (addr == 16'h200A),
            ok & rw  & (addr == 16'h2004),
            ok & rw  & (addr == 16'h2008) & bite_active & xmit_irq,
            ok & ~rw & (addr == 16'h0006),
            ok & ~rw & (addr == 16'h0007)};
  endfunction

  function automatic logic [8:0] exp_rd();
    logic ok = vma & phi2 & ~ba & rw;
    if (ok && addr == 16'h2000)
      return {1'b1, xdet, fsel, link_fault, m_down, m_air, enc_standby, halt_st, 1'b0};
    if (ok && addr == 16'h2002)
      return {1'b1, 6'b0, ant_right, 1'b0};
    return 9'h000;
  endfunction

  function automatic logic [2:0] exp_bus();
    logic on = ~ba & vma & phi2;
    return {~on, on & rw, ba};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h addr=%h", req, act, exp, addr);
    end
  endtask

  // compare all outputs against the model; then advance model through the edge
  task automatic step(input string req);
    #5;
    chk({req, " R1/R2/R3/R4 strobes"},
        {27'b0, drift_rd_stb, adas_rd_stb, rx_rd_stb, txlo_wr_stb, txhi_wr_stb},
        {27'b0, exp_stb()});
    chk({req, " R5/R6/R9 status"}, {23'b0, rd_oe, rd_data}, {23'b0, exp_rd()});
    chk({req, " R10/R11 bus"}, {29'b0, xcvr_en_n, xcvr_to_cpu, addr_drv_en_n},
        {29'b0, exp_bus()});
    if (rst_n) begin
      m_air  = air_test_req  | (m_air  & ~(vma & phi2 & ~ba & ~rw & (addr == 16'h2000)));
      m_down = down_test_req | (m_down & ~(vma & phi2 & ~ba & ~rw & (addr == 16'h2000)));
    end
    @(negedge clk);
  endtask

  task automatic bus(input logic [15:0] a, input logic r);
    addr = a; rw = r; vma = 1; phi2 = 1; ba = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    // R12: flags stay clear in reset even with requests high
    air_test_req = 1; down_test_req = 1;
    bus(16'h2000, 1);
    step("R12 reset");
    step("R12 reset");
    air_test_req = 0; down_test_req = 0;
    rst_n = 1;
    step("R12 sync release");
    step("R12 sync release");
    step("R12 after release");

    // R1, R2, R3 directed
    bus(16'h200A, 1); step("R1 drift");
    bus(16'h2004, 1); step("R1 adas");
    bus(16'h0006, 0); step("R2 txlo");
    bus(16'h0007, 0); step("R2 txhi");
    bus(16'h2008, 1); bite_active = 1; xmit_irq = 0; step("R3 no irq");
    xmit_irq = 1; step("R3 granted");
    bite_active = 0; step("R3 no bite");
    // R4: qualifiers and direction
    bus(16'h200A, 0); step("R4 wrong dir");
    bus(16'h0006, 1); step("R4 wrong dir");
    bus(16'h2004, 1); vma = 0; step("R4 vma low");
    bus(16'h2004, 1); phi2 = 0; step("R4 phi2 low");
    bus(16'h2004, 1); ba = 1; step("R4/R11 ba high");
    // R5, R6
    xdet = 1; fsel = 0; link_fault = 1; enc_standby = 1; halt_st = 1; ant_right = 1;
    bus(16'h2000, 1); step("R5 status");
    bus(16'h2002, 1); step("R6 antenna");
    // R7: pulse request, then read
    bus(16'h1234, 1); air_test_req = 1; step("R7 set");
    air_test_req = 0;
    bus(16'h2000, 1); step("R7 hold");
    step("R7 hold");
    // R8: clear, and clear coinciding with request
    bus(16'h2000, 0); step("R8 clear");
    bus(16'h2000, 1); step("R8 cleared");
    down_test_req = 1; step("R8 set");
    bus(16'h2000, 0); air_test_req = 1; step("R8 clear vs set");
    air_test_req = 0; down_test_req = 0;
    bus(16'h2000, 1); step("R8 set wins");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] pick [8] = '{16'h200A, 16'h2004, 16'h2008, 16'h0006,
                               16'h0007, 16'h2000, 16'h2002, 16'h0000};
      logic [3:0] sel = 4'($urandom_range(0, 9));
      addr = (sel < 7) ? pick[sel[2:0]] : 16'($urandom);
      rw   = 1'($urandom); vma = ($urandom_range(0, 7) != 0);
      phi2 = ($urandom_range(0, 7) != 0); ba = ($urandom_range(0, 7) == 0);
      bite_active = 1'($urandom); xmit_irq = 1'($urandom);
      {xdet, fsel, halt_st, link_fault, enc_standby, ant_right} = 6'($urandom);
      air_test_req  = ($urandom_range(0, 15) == 0);
      down_test_req = ($urandom_range(0, 15) == 0);
      step("R1-random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule